// File: doc/BRIEF.md
# Trigger-Driven ADC Command Sequencer

This block keeps a list of 16-bit conversion commands for a pair of ADC units and plays out a run of them each time a trigger source fires. Every trigger source owns a start index into the list. From that index the sequencer examines entries one after another, wrapping past the last entry, and hands each valid command to the converters through a valid/acknowledge handshake. It then waits for a completion pulse before it moves on. A run carries no length field. It stops at the next entry whose run-start bit is set.

Software edits a shadow copy of the list and of the start indices. The sequencer only ever reads the active copy, which takes the shadow contents on a master reload that is flagged as valid. Each entry is decoded as either a single conversion on one unit or a simultaneous conversion on both units. A dual command that would make both units sample the same shared physical input is dropped and recorded in a sticky error flag. Commands marked for interrupt produce a one-cycle interrupt pulse when they complete. A trigger that arrives while a run is still in progress is dropped and recorded in a sticky overrun flag.

Top module: `adc_cmd_seq`

## Requirements
- R1: After reset `cmd_valid_o`, `irq_o`, `err_o`, `ovr_o` and `seq_mode_o` are all 0, and the active list and all start indices are all-zero.
- R2: The first write on `mode_wr_i` sets `seq_mode_o` to `mode_val_i`. Later writes have no effect until reset. While `seq_mode_o` is 0, triggers produce no command and do not set overrun.
- R3: Writes to the shadow list and to the shadow start indices do not change the commands issued until `reload_i` is high together with `reload_ok_i`. A reload with `reload_ok_i` low changes nothing.
- R4: A trigger on source t starts a run at the active start index of t. When several sources fire in the same cycle, the lowest-numbered source wins.
- R5: The entry at the start index is always evaluated, whatever its bit 14 holds. Each later entry ends the run, without being issued, when its bit 14 (run start) is 1. The index after entry 23 is entry 0.
- R6: A run examines at most 24 entries (the list size), even if no entry has bit 14 set.
- R7: An entry with bit 13 = 0 is a single command. `cmd_unit_o` = bit 4 (0 = unit A, 1 = unit B), `cmd_chan_a_o` = bits 3:0, `cmd_chan_b_o` = 0, `cmd_dual_o` = 0, and `cmd_fifo_o` = bits 12:11.
- R8: An entry with bit 13 = 1 is a dual command. `cmd_dual_o` = 1, `cmd_chan_a_o` = bits 3:0, `cmd_chan_b_o` = bits 7:4, `cmd_unit_o` = 0, and `cmd_fifo_o` = bits 12:11.
- R9: A dual command whose two channel numbers are equal and lie in 12..15 is not issued. It sets the sticky `err_o`, and the run goes on with the next entry. Equal numbers below 12, or two different shared numbers, are valid.
- R10: A command is held unchanged on the outputs until `cmd_ack_i`. The next command is not presented before `done_i` has been seen.
- R11: When `done_i` completes a command whose bit 15 is 1, `irq_o` is high for exactly the following cycle. Otherwise `irq_o` stays low.
- R12: A trigger that arrives while a run is active sets the sticky `ovr_o` and does not start or alter a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Write strobe for the one-time control-mode select |
| mode_val_i | input | 1 | Control mode value (1 = sequencer drives the ADCs) |
| sh_wr_i | input | 1 | Shadow list entry write strobe |
| sh_idx_i | input | 5 | Shadow list entry index |
| sh_data_i | input | 16 | Shadow list entry data |
| st_wr_i | input | 1 | Shadow start-index write strobe |
| st_src_i | input | 2 | Trigger source whose start index is written |
| st_idx_i | input | 5 | Start index value |
| reload_i | input | 1 | Master reload event |
| reload_ok_i | input | 1 | Reload is valid; shadow contents are copied when high with reload_i |
| trig_i | input | 4 | Trigger pulses, one per source |
| cmd_valid_o | output | 1 | Command presented to the converters |
| cmd_ack_i | input | 1 | Converters accept the presented command |
| cmd_dual_o | output | 1 | 1 = dual conversion |
| cmd_unit_o | output | 1 | Unit select for single conversion (0 = A, 1 = B) |
| cmd_chan_a_o | output | 4 | Channel for unit A, or for the single-mode unit |
| cmd_chan_b_o | output | 4 | Channel for unit B in dual mode |
| cmd_fifo_o | output | 2 | Result FIFO select |
| done_i | input | 1 | Converters finished the accepted command |
| irq_o | output | 1 | Interrupt request pulse |
| err_o | output | 1 | Sticky invalid-command flag |
| ovr_o | output | 1 | Sticky trigger-overrun flag |
| seq_mode_o | output | 1 | Current control mode |

## Verification
The list is first played from its all-zero reset contents. Such a list has no run-start bit anywhere, so only the 24-entry bound can end the run, and the same run before and after an invalid reload shows that shadow edits stay hidden. A programmed list then drives runs that tell single from dual decoding, end at a run-start bit across the 23-to-0 wrap, and skip an invalid shared-channel pair while keeping equal non-shared numbers and distinct shared numbers. Simultaneous triggers separate source priority from arrival order, and a trigger during a run shows that overrun leaves the issued sequence unchanged. The acknowledge is delayed by varying amounts, so a command that is dropped early or advanced before completion shows up as a missing or surplus item in the scoreboard.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CMD_W      = 16;
    localparam int CH_W       = 4;
    localparam int FIFO_W     = 2;

    // entry field positions
    localparam int B_IRQ      = 15;
    localparam int B_RUN_HEAD = 14;
    localparam int B_DUAL     = 13;
    localparam int B_FIFO_LO  = 11;
    localparam int B_UNIT     = 4;
    localparam int B_CHB_LO   = 4;

    localparam logic [CH_W-1:0] SHARED_LO = 4'd12;

    typedef struct packed {
        logic              irq;
        logic              head;
        logic              dual;
        logic [FIFO_W-1:0] fifo;
        logic              unit;
        logic [CH_W-1:0]   chan_a;
        logic [CH_W-1:0]   chan_b;
        logic              bad;
    } cmd_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT
    } seq_st_e;

endpackage

// File: rtl/cmd_list_store.sv
module cmd_list_store
    import adc_seq_pkg::*;
#(
    parameter int N_ENTRIES = 24,
    parameter int N_TRIG    = 4,
    parameter int IDX_W     = $clog2(N_ENTRIES),
    parameter int SRC_W     = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sh_wr_i,
    input  logic [IDX_W-1:0]              sh_idx_i,
    input  logic [CMD_W-1:0]              sh_data_i,
    input  logic                          st_wr_i,
    input  logic [SRC_W-1:0]              st_src_i,
    input  logic [IDX_W-1:0]              st_idx_i,
    input  logic                          reload_i,
    input  logic                          reload_ok_i,
    input  logic [IDX_W-1:0]              rd_idx_i,
    output logic [CMD_W-1:0]              rd_data_o,
    output logic [N_TRIG-1:0][IDX_W-1:0]  start_o
);

    typedef struct packed {
        logic [N_ENTRIES-1:0][CMD_W-1:0] sh_list;
        logic [N_ENTRIES-1:0][CMD_W-1:0] act_list;
        logic [N_TRIG-1:0][IDX_W-1:0]    sh_start;
        logic [N_TRIG-1:0][IDX_W-1:0]    act_start;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (sh_wr_i && (sh_idx_i == IDX_W'(i))) begin
                s_d.sh_list[i] = sh_data_i;
            end
        end
        for (int j = 0; j < N_TRIG; j++) begin
            if (st_wr_i && (st_src_i == SRC_W'(j)) && (st_idx_i < IDX_W'(N_ENTRIES))) begin
                s_d.sh_start[j] = st_idx_i;
            end
        end
        if (reload_i && reload_ok_i) begin
            s_d.act_list  = s_q.sh_list;
            s_d.act_start = s_q.sh_start;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (rd_idx_i == IDX_W'(i)) begin
                rd_data_o = s_q.act_list[i];
            end
        end
    end

    assign start_o = s_q.act_start;

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reload_i && reload_ok_i) |=> $stable(s_q.act_list) && $stable(s_q.act_start)); // R3

endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import adc_seq_pkg::*;
(
    input  logic [CMD_W-1:0] raw_i,
    output cmd_dec_t         dec_o
);

    logic dual;
    logic same_shared;

    assign dual        = raw_i[B_DUAL];
    assign same_shared = (raw_i[CH_W-1:0] == raw_i[B_CHB_LO +: CH_W])
                       && (raw_i[CH_W-1:0] >= SHARED_LO);

    always_comb begin
        dec_o        = '0;
        dec_o.irq    = raw_i[B_IRQ];
        dec_o.head   = raw_i[B_RUN_HEAD];
        dec_o.dual   = dual;
        dec_o.fifo   = raw_i[B_FIFO_LO +: FIFO_W];
        dec_o.chan_a = raw_i[CH_W-1:0];
        if (dual) begin
            dec_o.chan_b = raw_i[B_CHB_LO +: CH_W];
            dec_o.bad    = same_shared;
        end else begin
            dec_o.unit   = raw_i[B_UNIT];
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int N_ENTRIES = 24,
    parameter int N_TRIG    = 4,
    parameter int IDX_W     = $clog2(N_ENTRIES),
    parameter int SRC_W     = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_wr_i,
    input  logic                          mode_val_i,
    input  logic [N_TRIG-1:0]             trig_i,
    input  logic [N_TRIG-1:0][IDX_W-1:0]  start_i,
    input  cmd_dec_t                      dec_i,
    output logic [IDX_W-1:0]              rd_idx_o,
    output logic                          cmd_valid_o,
    input  logic                          cmd_ack_i,
    output cmd_dec_t                      cmd_o,
    input  logic                          done_i,
    output logic                          irq_o,
    output logic                          err_o,
    output logic                          ovr_o,
    output logic                          seq_mode_o
);

    localparam int CNT_W = $clog2(N_ENTRIES + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] seen;
        logic             at_head;
        cmd_dec_t         cur;
        logic             mode;
        logic             locked;
        logic             err;
        logic             ovr;
        logic             irq;
    } ctl_t;

    ctl_t c_d, c_q;
    logic             trig_hit;
    logic [SRC_W-1:0] pick;
    logic [IDX_W-1:0] idx_next;

    assign trig_hit = (|trig_i) && c_q.mode;
    assign idx_next = (c_q.idx == IDX_W'(N_ENTRIES - 1)) ? '0 : c_q.idx + 1'b1;

    always_comb begin
        pick = '0;
        for (int i = N_TRIG - 1; i >= 0; i--) begin
            if (trig_i[i]) begin
                pick = SRC_W'(i);
            end
        end
    end

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;

        if (mode_wr_i && !c_q.locked) begin
            c_d.mode   = mode_val_i;
            c_d.locked = 1'b1;
        end

        if (trig_hit && (c_q.st != ST_IDLE)) begin
            c_d.ovr = 1'b1;
        end

        unique case (c_q.st)
            ST_IDLE: begin
                if (trig_hit) begin
                    c_d.idx     = start_i[pick];
                    c_d.seen    = '0;
                    c_d.at_head = 1'b1;
                    c_d.st      = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if ((c_q.seen == CNT_W'(N_ENTRIES)) || (!c_q.at_head && dec_i.head)) begin
                    c_d.st = ST_IDLE;
                end else if (dec_i.bad) begin
                    c_d.err     = 1'b1;
                    c_d.idx     = idx_next;
                    c_d.seen    = c_q.seen + 1'b1;
                    c_d.at_head = 1'b0;
                end else begin
                    c_d.cur = dec_i;
                    c_d.st  = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (cmd_ack_i) begin
                    c_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (done_i) begin
                    c_d.irq     = c_q.cur.irq;
                    c_d.idx     = idx_next;
                    c_d.seen    = c_q.seen + 1'b1;
                    c_d.at_head = 1'b0;
                    c_d.st      = ST_CHECK;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_idx_o    = c_q.idx;
    assign cmd_valid_o = (c_q.st == ST_ISSUE);
    assign cmd_o       = c_q.cur;
    assign irq_o       = c_q.irq;
    assign err_o       = c_q.err;
    assign ovr_o       = c_q.ovr;
    assign seq_mode_o  = c_q.mode;

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_o)); // R10
    AST_NO_NEXT_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_ack_i |=> !cmd_valid_o); // R10
    AST_QUIET_IN_CPU_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_mode_o |-> !cmd_valid_o && !ovr_o); // R2
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.locked |=> $stable(seq_mode_o)); // R2
    AST_NO_BAD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_o.dual |-> !((cmd_o.chan_a == cmd_o.chan_b) && (cmd_o.chan_a >= SHARED_LO))); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |=> ovr_o); // R12
    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(done_i)); // R11
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R11

endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
    import adc_seq_pkg::*;
#(
    parameter int N_ENTRIES = 24,
    parameter int N_TRIG    = 4,
    parameter int IDX_W     = $clog2(N_ENTRIES),
    parameter int SRC_W     = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr_i,
    input  logic              mode_val_i,
    input  logic              sh_wr_i,
    input  logic [IDX_W-1:0]  sh_idx_i,
    input  logic [15:0]       sh_data_i,
    input  logic              st_wr_i,
    input  logic [SRC_W-1:0]  st_src_i,
    input  logic [IDX_W-1:0]  st_idx_i,
    input  logic              reload_i,
    input  logic              reload_ok_i,
    input  logic [N_TRIG-1:0] trig_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ack_i,
    output logic              cmd_dual_o,
    output logic              cmd_unit_o,
    output logic [3:0]        cmd_chan_a_o,
    output logic [3:0]        cmd_chan_b_o,
    output logic [1:0]        cmd_fifo_o,
    input  logic              done_i,
    output logic              irq_o,
    output logic              err_o,
    output logic              ovr_o,
    output logic              seq_mode_o
);

    logic [IDX_W-1:0]             rd_idx;
    logic [CMD_W-1:0]             rd_data;
    logic [N_TRIG-1:0][IDX_W-1:0] start;
    cmd_dec_t                     dec;
    cmd_dec_t                     cmd;

    cmd_list_store #(
        .N_ENTRIES (N_ENTRIES),
        .N_TRIG    (N_TRIG),
        .IDX_W     (IDX_W),
        .SRC_W     (SRC_W)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sh_wr_i     (sh_wr_i),
        .sh_idx_i    (sh_idx_i),
        .sh_data_i   (sh_data_i),
        .st_wr_i     (st_wr_i),
        .st_src_i    (st_src_i),
        .st_idx_i    (st_idx_i),
        .reload_i    (reload_i),
        .reload_ok_i (reload_ok_i),
        .rd_idx_i    (rd_idx),
        .rd_data_o   (rd_data),
        .start_o     (start)
    );

    cmd_decode dec_i0 (
        .raw_i (rd_data),
        .dec_o (dec)
    );

    seq_ctrl #(
        .N_ENTRIES (N_ENTRIES),
        .N_TRIG    (N_TRIG),
        .IDX_W     (IDX_W),
        .SRC_W     (SRC_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr_i   (mode_wr_i),
        .mode_val_i  (mode_val_i),
        .trig_i      (trig_i),
        .start_i     (start),
        .dec_i       (dec),
        .rd_idx_o    (rd_idx),
        .cmd_valid_o (cmd_valid_o),
        .cmd_ack_i   (cmd_ack_i),
        .cmd_o       (cmd),
        .done_i      (done_i),
        .irq_o       (irq_o),
        .err_o       (err_o),
        .ovr_o       (ovr_o),
        .seq_mode_o  (seq_mode_o)
    );

    assign cmd_dual_o   = cmd.dual;
    assign cmd_unit_o   = cmd.unit;
    assign cmd_chan_a_o = cmd.chan_a;
    assign cmd_chan_b_o = cmd.chan_b;
    assign cmd_fifo_o   = cmd.fifo;

endmodule

// File: tb/adc_cmd_seq_tb_top.sv
module adc_cmd_seq_tb_top;

    localparam int NE = 24;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr_i = 1'b0, mode_val_i = 1'b0;
    logic        sh_wr_i = 1'b0;
    logic [4:0]  sh_idx_i = '0;
    logic [15:0] sh_data_i = '0;
    logic        st_wr_i = 1'b0;
    logic [1:0]  st_src_i = '0;
    logic [4:0]  st_idx_i = '0;
    logic        reload_i = 1'b0, reload_ok_i = 1'b0;
    logic [3:0]  trig_i = '0;
    logic        cmd_valid_o, cmd_ack_i = 1'b0;
    logic        cmd_dual_o, cmd_unit_o;
    logic [3:0]  cmd_chan_a_o, cmd_chan_b_o;
    logic [1:0]  cmd_fifo_o;
    logic        done_i = 1'b0;
    logic        irq_o, err_o, ovr_o, seq_mode_o;

    always #2.5 clk = ~clk;

    adc_cmd_seq dut_i (.*);

    int n_cmp = 0;
    int n_mis = 0;
    int irq_seen = 0;
    int irq_exp = 0;
    bit err_exp = 0;
    logic [11:0] exp_q [$];

    logic [15:0] sh_m  [NE];
    logic [15:0] act_m [NE];
    logic [4:0]  shs_m [NT];
    logic [4:0]  acts_m [NT];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] item_of(logic [15:0] e);
        if (e[13]) return {1'b1, 1'b0, e[3:0], e[7:4], e[12:11]};      // R8
        else       return {1'b0, e[4], e[3:0], 4'd0, e[12:11]};        // R7
    endfunction

    function automatic logic [15:0] mk_single(bit irq, bit hd, logic [1:0] f, bit u, logic [3:0] ch);
        return {irq, hd, 1'b0, f, 6'd0, u, ch};
    endfunction

    function automatic logic [15:0] mk_dual(bit irq, bit hd, logic [1:0] f, logic [3:0] a, logic [3:0] b);
        return {irq, hd, 1'b1, f, 3'd0, b, a};
    endfunction

    // expected run from the active model (R4, R5, R6, R9, R11)
    task automatic expect_run(int src);
        int  idx = acts_m[src];
        bit  head = 1;
        for (int k = 0; k < NE; k++) begin
            logic [15:0] e = act_m[idx];
            if (!head && e[14]) break;
            head = 0;
            if (e[13] && e[3:0] == e[7:4] && e[3:0] >= 4'd12) err_exp = 1;
            else begin
                exp_q.push_back(item_of(e));
                if (e[15]) irq_exp++;
            end
            idx = (idx + 1) % NE;
        end
    endtask

    // monitor: varied ack delay, then done
    int ack_dly = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid_o) begin
                logic [11:0] got;
                repeat (ack_dly) @(negedge clk);
                ack_dly = (ack_dly + 1) % 3;
                got = {cmd_dual_o, cmd_unit_o, cmd_chan_a_o, cmd_chan_b_o, cmd_fifo_o};
                if (exp_q.size() == 0) chk("R10 unexpected command", {20'd0, got}, 32'hFFFF_FFFF);
                else chk("R7/R8 command", {20'd0, got}, {20'd0, exp_q.pop_front()});
                cmd_ack_i = 1'b1;
                @(negedge clk);
                cmd_ack_i = 1'b0;
                for (int w = 0; w < 3; w++) begin
                    if (cmd_valid_o) chk("R10 command before done", 32'd1, 32'd0);
                    @(negedge clk);
                end
                done_i = 1'b1;
                @(negedge clk);
                done_i = 1'b0;
            end
        end
    end

    always @(negedge clk) if (irq_o) irq_seen++;

    task automatic pulse_trig(logic [3:0] t);
        @(negedge clk); trig_i = t;
        @(negedge clk); trig_i = '0;
    endtask

    task automatic settle();
        repeat (400) @(negedge clk);
        chk("R5/R6 queue drained", exp_q.size(), 0);
    endtask

    task automatic wr_entry(int i, logic [15:0] v);
        @(negedge clk); sh_wr_i = 1; sh_idx_i = 5'(i); sh_data_i = v; sh_m[i] = v;
        @(negedge clk); sh_wr_i = 0;
    endtask

    task automatic wr_start(int s, int i);
        @(negedge clk); st_wr_i = 1; st_src_i = 2'(s); st_idx_i = 5'(i); shs_m[s] = 5'(i);
        @(negedge clk); st_wr_i = 0;
    endtask

    task automatic do_reload(bit ok);
        @(negedge clk); reload_i = 1; reload_ok_i = ok;
        @(negedge clk); reload_i = 0; reload_ok_i = 0;
        if (ok) begin
            for (int i = 0; i < NE; i++) act_m[i] = sh_m[i];
            for (int s = 0; s < NT; s++) acts_m[s] = shs_m[s];
        end
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin sh_m[i] = '0; act_m[i] = '0; end
        for (int s = 0; s < NT; s++) begin shs_m[s] = '0; acts_m[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd_valid", cmd_valid_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 err", err_o, 0);
        chk("R1 ovr", ovr_o, 0);
        chk("R1 mode", seq_mode_o, 0);

        // R2: triggers ignored in CPU mode
        pulse_trig(4'b0001);
        settle();
        chk("R2 no overrun in cpu mode", ovr_o, 0);

        // R2: mode locks
        @(negedge clk); mode_wr_i = 1; mode_val_i = 1;
        @(negedge clk); mode_val_i = 0;
        @(negedge clk); mode_wr_i = 0;
        chk("R2 mode locked at 1", seq_mode_o, 1);

        // program shadow
        for (int i = 0; i < NE; i++) wr_entry(i, mk_single(0, 1, 2'(i % 4), i[0], 4'(i % 16)));
        wr_entry(0,  mk_single(1, 1, 2'd2, 1, 4'd5));
        wr_entry(1,  mk_single(0, 0, 2'd1, 0, 4'd3));
        wr_entry(2,  mk_dual(1, 0, 2'd3, 4'd2, 4'd7));
        wr_entry(3,  mk_dual(0, 0, 2'd0, 4'd13, 4'd13));
        wr_entry(4,  mk_dual(0, 0, 2'd1, 4'd5, 4'd5));
        wr_entry(5,  mk_dual(0, 1, 2'd0, 4'd12, 4'd13));
        wr_entry(10, mk_dual(0, 1, 2'd2, 4'd14, 4'd14));
        wr_entry(22, mk_single(0, 1, 2'd1, 0, 4'd9));
        wr_entry(23, mk_single(1, 0, 2'd3, 1, 4'd14));
        wr_start(0, 0); wr_start(1, 22); wr_start(2, 5); wr_start(3, 10);

        // R3 + R6: no reload yet, zero list runs 24 entries
        expect_run(0);
        chk("R6 24 zero commands expected", exp_q.size(), 24);
        pulse_trig(4'b0001);
        settle();
        chk("R9 no error on valid list", err_o, 0);

        // R3: reload without ok changes nothing
        do_reload(0);
        expect_run(0);
        pulse_trig(4'b0001);
        settle();

        // R3 valid reload; run 0: single/dual, invalid skipped, irq
        do_reload(1);
        irq_seen = 0; irq_exp = 0;
        expect_run(0);
        chk("R9 model sees four issued", exp_q.size(), 4);
        pulse_trig(4'b0001);
        settle();
        chk("R9 err sticky set", err_o, err_exp);
        chk("R11 irq pulses", irq_seen, irq_exp);

        // R5: wrap 23 -> 0 ends at head bit
        irq_seen = 0; irq_exp = 0;
        expect_run(1);
        pulse_trig(4'b0010);
        settle();
        chk("R11 irq pulses wrap run", irq_seen, irq_exp);

        // R9: distinct shared channels valid
        expect_run(2);
        pulse_trig(4'b0100);
        settle();

        // R9: invalid-only run issues nothing
        expect_run(3);
        chk("R9 invalid-only run empty", exp_q.size(), 0);
        pulse_trig(4'b1000);
        settle();
        chk("R9 err still set", err_o, 1);

        // R4: priority, lowest source wins
        expect_run(1);
        pulse_trig(4'b0110);
        settle();
        chk("R12 no overrun yet", ovr_o, 0);

        // R12: overrun
        expect_run(0);
        pulse_trig(4'b0001);
        repeat (3) @(negedge clk);
        pulse_trig(4'b0100);
        settle();
        chk("R12 overrun sticky", ovr_o, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_mis++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

endmodule